// File: doc/BRIEF.md
# DMA Transfer Request Command Decoder

This block sits between an external requesting device and a four-channel DMA engine. The device sends a 7-bit request word over a valid/ready handshake. A word that names channel 1, 2 or 3 is a plain transfer request and is pushed into that channel's request queue. A word that names channel 0 is a command. The mode and size fields of the word choose one of three commands: a data-bus handshake request, an end-of-transfer command, or a command that flushes every held request.

The block keeps the channel 0 enable bit, the channel 0 source address, destination address and transfer count, a busy flag for channel 0, and a freeze flag for the DMA engine. Channel 0 commands are gated by whether channel 0 is enabled and whether a channel 0 bus cycle is running. Software writes the channel 0 settings, and is the only way to re-enable channel 0 after an end-of-transfer command. The DMA datapath grants and finishes channel 0 cycles and pops the channel 1 to 3 queues.

Top module: `dma_req_decoder`

## Requirements
- R1: After reset, req_ready is 0 while rst is high and 1 from the first clock after rst falls. ch0_en, ch0_req, ch0_busy, frozen, all queue levels, all overflow flags and the settings registers are 0.
- R2: A word is accepted only in a cycle with req_valid and req_ready both high. Its fields are channel ID at bits [6:5], mode at [4:3] and size at [2:0]. When the ID is nonzero, the word raises the level of queue ID by one on the next clock, whatever its mode and size. Queue k's level is at q_level[3k-1:3k-3] and its overflow flag is at q_overflow[k-1].
- R3: A queue holds at most Q_DEPTH (4) requests. A push into a full queue is dropped, even if a pop comes in the same cycle, and it sets that queue's overflow flag. The flag stays set until reset. A pop of an empty queue is ignored.
- R4: ID=0 with mode 0 and size neither 5 nor 6 is a handshake request. It sets ch0_req on the next clock when ch0_en is 1 and ch0_busy is 0.
- R5: A handshake request is dropped while ch0_busy is 1, and also while ch0_en is 0.
- R6: A ch0_grant while ch0_req is 1 clears ch0_req and sets ch0_busy. ch0_done clears ch0_busy, unless a grant sets it in the same cycle.
- R7: ID=0 with mode nonzero and size 7 is an end-of-transfer command. When ch0_busy is 0 it clears ch0_en and withdraws ch0_req. It leaves ch0_src, ch0_dst and ch0_cnt unchanged.
- R8: An end-of-transfer command that arrives while ch0_busy is 1 is ignored.
- R9: Handshake requests cannot set ch0_en. Only a software write with sw_sel=0 sets ch0_en, and it takes sw_wdata[0]. That write wins over an end-of-transfer command in the same cycle. sw_sel 1, 2 and 3 write ch0_src, ch0_dst and ch0_cnt (the low CNT_W bits).
- R10: ID=0 with mode 2 and size 6 clears ch0_req, every queue level and frozen. It takes priority over a pop or a freeze_set in the same cycle. It leaves the overflow flags unchanged.
- R11: Any other ID=0 word changes no state.
- R12: freeze_set sets frozen, which holds until a flush command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request word valid |
| req_ready | output | 1 | Block can accept a word |
| req_word | input | 7 | Request word: ID [6:5], mode [4:3], size [2:0] |
| ch0_grant | input | 1 | Datapath starts the pending channel 0 cycle |
| ch0_done | input | 1 | Datapath finished the channel 0 transfer |
| q_pop | input | 3 | Pop one request from queue k (bit k-1) |
| freeze_set | input | 1 | DMA engine entered the frozen state |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 enable, 1 source, 2 destination, 3 count |
| sw_wdata | input | ADDR_W | Software write data |
| ch0_req | output | 1 | Channel 0 handshake request pending |
| ch0_busy | output | 1 | Channel 0 bus cycle in progress |
| ch0_en | output | 1 | Channel 0 enable |
| ch0_src | output | ADDR_W | Channel 0 source address |
| ch0_dst | output | ADDR_W | Channel 0 destination address |
| ch0_cnt | output | CNT_W | Channel 0 transfer count |
| frozen | output | 1 | DMA freeze flag |
| q_level | output | 9 | Occupancy of queues 1 to 3, 3 bits each |
| q_overflow | output | 3 | Sticky overflow flag per queue |

## Verification
The bench drives end-of-transfer commands while channel 0 is busy. A design that failed to gate them would drop ch0_en in the middle of a burst. It sends handshake requests while busy and while disabled; a design that let these through would raise ch0_req it must not. It also sends the boundary size codes 5, 6 and 7 with each mode. A design that decoded mode 0 with size 7 as an end command, or that acted on an unlisted combination, would show a wrong enable or pending state. It fills queues past four and pops them while full or empty, and it sends a flush in the same cycle as pops and freeze_set. Here an off-by-one full test, an overflow flag that clears itself, or a wrong priority order would show up as a level or flag that differs from the model.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_HS   = 2'd1,
    CMD_TEND = 2'd2,
    CMD_QCLR = 2'd3
  } ch0_cmd_t;

  typedef struct packed {
    logic [1:0] id;
    logic [1:0] mode;
    logic [2:0] size;
  } req_word_t;

  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_SRC = 2'd1;
  localparam logic [1:0] SEL_DST = 2'd2;
  localparam logic [1:0] SEL_CNT = 2'd3;
endpackage

// File: rtl/dreq_decode.sv
`timescale 1ns/1ps
module dreq_decode
  import dreq_pkg::*;
#(
  parameter int N_QCH = 3
) (
  input  logic             acc,
  input  req_word_t        word,
  output ch0_cmd_t         cmd,
  output logic [N_QCH-1:0] push
);
  always_comb begin
    cmd = CMD_NONE;
    if (acc && word.id == 2'd0) begin
      if (word.mode == 2'd2 && word.size == 3'd6)
        cmd = CMD_QCLR;
      else if (word.mode != 2'd0 && word.size == 3'd7)
        cmd = CMD_TEND;
      else if (word.mode == 2'd0 && word.size != 3'd5 && word.size != 3'd6)
        cmd = CMD_HS;
    end
  end

  for (genvar k = 0; k < N_QCH; k++) begin : g_push
    assign push[k] = acc && (word.id == 2'(k + 1));
  end
endmodule

// File: rtl/dreq_queue.sv
`timescale 1ns/1ps
module dreq_queue #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic [CW-1:0] level,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic is_full, is_empty, push_ok, pop_ok;
  assign is_full  = (level == FULL);
  assign is_empty = (level == '0);
  assign push_ok  = push && !is_full;
  assign pop_ok   = pop && !is_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (clr)
        level <= '0;
      else if (push_ok && !pop_ok)
        level <= level + 1'b1;
      else if (pop_ok && !push_ok)
        level <= level - 1'b1;
      if (push && is_full)
        ovf <= 1'b1;
    end
  end

  // R3: occupancy never exceeds depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);
  // R3: overflow flag is sticky
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R3: a push into a full queue leaves it full and flags overflow
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && is_full && !clr && !pop) |=> (ovf && level == FULL));
  // R10: flush empties the queue
  a_r10_clr_empty: assert property (@(posedge clk) disable iff (rst)
    clr |=> level == '0);
endmodule

// File: rtl/dreq_ch0_ctrl.sv
`timescale 1ns/1ps
module dreq_ch0_ctrl
  import dreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  ch0_cmd_t          cmd,
  input  logic              grant,
  input  logic              done,
  input  logic              freeze_set,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [ADDR_W-1:0] sw_wdata,
  output logic              pending,
  output logic              busy,
  output logic              en,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output logic              frozen
);
  logic hs_acc, tend_acc, qclr, grant_ok, en_wr;
  assign hs_acc   = (cmd == CMD_HS) && en && !busy;
  assign tend_acc = (cmd == CMD_TEND) && !busy;
  assign qclr     = (cmd == CMD_QCLR);
  assign grant_ok = grant && pending;
  assign en_wr    = sw_we && (sw_sel == SEL_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      en      <= 1'b0;
      src     <= '0;
      dst     <= '0;
      cnt     <= '0;
      frozen  <= 1'b0;
    end else begin
      if (grant_ok)
        busy <= 1'b1;
      else if (done)
        busy <= 1'b0;

      if (qclr || tend_acc)
        pending <= 1'b0;
      else if (grant_ok)
        pending <= 1'b0;
      else if (hs_acc)
        pending <= 1'b1;

      if (en_wr)
        en <= sw_wdata[0];
      else if (tend_acc)
        en <= 1'b0;

      if (sw_we && sw_sel == SEL_SRC) src <= sw_wdata;
      if (sw_we && sw_sel == SEL_DST) dst <= sw_wdata;
      if (sw_we && sw_sel == SEL_CNT) cnt <= sw_wdata[CNT_W-1:0];

      if (qclr)
        frozen <= 1'b0;
      else if (freeze_set)
        frozen <= 1'b1;
    end
  end

  // R5: handshake during a busy cycle does not create a request
  a_r5_hs_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HS && busy && !pending) |=> !pending);
  // R8: end command while busy keeps the enable
  a_r8_tend_busy_keep: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TEND && busy && en && !sw_we) |=> en);
  // R7: accepted end command clears enable and keeps settings
  a_r7_tend_keep_regs: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TEND && !busy && !sw_we) |=> (!en && !pending && $stable(src) && $stable(dst) && $stable(cnt)));
  // R10: flush clears pending and freeze
  a_r10_qclr: assert property (@(posedge clk) disable iff (rst)
    qclr |=> (!pending && !frozen));
  // R9: enable rises only through a software write
  a_r9_en_rise_sw: assert property (@(posedge clk) disable iff (rst)
    (!en && !en_wr) |=> !en);
  // R6: grant of a pending request starts a busy cycle
  a_r6_grant_busy: assert property (@(posedge clk) disable iff (rst)
    grant_ok |=> (busy && !pending));
endmodule

// File: rtl/dma_req_decoder.sv
`timescale 1ns/1ps
module dma_req_decoder
  import dreq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 24,
  parameter int Q_DEPTH = 4,
  localparam int N_QCH  = 3,
  localparam int QCW    = $clog2(Q_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [6:0]           req_word,
  input  logic                 ch0_grant,
  input  logic                 ch0_done,
  input  logic [N_QCH-1:0]     q_pop,
  input  logic                 freeze_set,
  input  logic                 sw_we,
  input  logic [1:0]           sw_sel,
  input  logic [ADDR_W-1:0]    sw_wdata,
  output logic                 ch0_req,
  output logic                 ch0_busy,
  output logic                 ch0_en,
  output logic [ADDR_W-1:0]    ch0_src,
  output logic [ADDR_W-1:0]    ch0_dst,
  output logic [CNT_W-1:0]     ch0_cnt,
  output logic                 frozen,
  output logic [N_QCH*QCW-1:0] q_level,
  output logic [N_QCH-1:0]     q_overflow
);
  logic             acc;
  ch0_cmd_t         cmd;
  logic [N_QCH-1:0] push;
  logic             qclr;

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  assign acc  = req_valid && req_ready;
  assign qclr = (cmd == CMD_QCLR);

  dreq_decode #(.N_QCH(N_QCH)) u_dec (
    .acc  (acc),
    .word (req_word_t'(req_word)),
    .cmd  (cmd),
    .push (push)
  );

  dreq_ch0_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ch0 (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .grant      (ch0_grant),
    .done       (ch0_done),
    .freeze_set (freeze_set),
    .sw_we      (sw_we),
    .sw_sel     (sw_sel),
    .sw_wdata   (sw_wdata),
    .pending    (ch0_req),
    .busy       (ch0_busy),
    .en         (ch0_en),
    .src        (ch0_src),
    .dst        (ch0_dst),
    .cnt        (ch0_cnt),
    .frozen     (frozen)
  );

  for (genvar k = 0; k < N_QCH; k++) begin : g_q
    dreq_queue #(.DEPTH(Q_DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (push[k]),
      .pop   (q_pop[k]),
      .clr   (qclr),
      .level (q_level[k*QCW +: QCW]),
      .ovf   (q_overflow[k])
    );
  end

  // R2: no word is taken while not ready
  a_r2_no_acc_unready: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !acc);
  // R2: at most one queue is pushed per word
  a_r2_push_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push));
  // R11: a channel 0 word never pushes a queue
  a_r11_id0_no_push: assert property (@(posedge clk) disable iff (rst)
    (acc && req_word[6:5] == 2'd0) |-> push == '0);
endmodule

// File: tb/dma_req_decoder_tb_top.sv
`timescale 1ns/1ps
module dma_req_decoder_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready;
  logic [6:0] req_word;
  logic ch0_grant, ch0_done, freeze_set, sw_we;
  logic [2:0] q_pop;
  logic [1:0] sw_sel;
  logic [ADDR_W-1:0] sw_wdata;
  logic ch0_req, ch0_busy, ch0_en, frozen;
  logic [ADDR_W-1:0] ch0_src, ch0_dst;
  logic [CNT_W-1:0] ch0_cnt;
  logic [8:0] q_level;
  logic [2:0] q_overflow;

  always #2 clk = ~clk;

  dma_req_decoder dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .ch0_grant(ch0_grant), .ch0_done(ch0_done),
    .q_pop(q_pop), .freeze_set(freeze_set), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .ch0_req(ch0_req), .ch0_busy(ch0_busy),
    .ch0_en(ch0_en), .ch0_src(ch0_src), .ch0_dst(ch0_dst), .ch0_cnt(ch0_cnt),
    .frozen(frozen), .q_level(q_level), .q_overflow(q_overflow)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  bit m_ready, m_pend, m_busy, m_en, m_frz;
  logic [ADDR_W-1:0] m_src, m_dst;
  logic [CNT_W-1:0] m_cnt;
  int m_lvl [3];
  bit m_ovf [3];

  // command classes from the requirements: 0 none, 1 hs, 2 end, 3 flush
  function automatic int classify(logic [6:0] w);
    logic [1:0] md = w[4:3];
    logic [2:0] sz = w[2:0];
    if (w[6:5] != 2'd0) return 0;
    if (md == 2'd2 && sz == 3'd6) return 3;
    if (md != 2'd0 && sz == 3'd7) return 2;
    if (md == 2'd0 && sz != 3'd5 && sz != 3'd6) return 1;
    return 0;
  endfunction

  function automatic logic [6:0] mk(int id, int md, int sz);
    return {2'(id), 2'(md), 3'(sz)};
  endfunction

  task automatic model_reset();
    m_ready = 0; m_pend = 0; m_busy = 0; m_en = 0; m_frz = 0;
    m_src = '0; m_dst = '0; m_cnt = '0;
    for (int k = 0; k < 3; k++) begin m_lvl[k] = 0; m_ovf[k] = 0; end
  endtask

  task automatic model_step();
    bit acc, grant_ok, hs_acc, tend_acc, clr;
    int c;
    acc = req_valid && m_ready;
    c = acc ? classify(req_word) : 0;
    clr = (c == 3);
    hs_acc = (c == 1) && m_en && !m_busy;
    tend_acc = (c == 2) && !m_busy;
    grant_ok = ch0_grant && m_pend;
    for (int k = 0; k < 3; k++) begin
      bit pu, po;
      pu = acc && (req_word[6:5] == 2'(k + 1));
      po = q_pop[k];
      if (pu && m_lvl[k] == DEPTH) m_ovf[k] = 1;
      if (clr) m_lvl[k] = 0;
      else begin
        if (pu && m_lvl[k] < DEPTH) m_lvl[k]++;
        else pu = 0;
        if (po && (m_lvl[k] - (pu ? 1 : 0)) > 0) m_lvl[k]--;
      end
    end
    if (clr || tend_acc) m_pend = 0;
    else if (grant_ok) m_pend = 0;
    else if (hs_acc) m_pend = 1;
    if (grant_ok) m_busy = 1; else if (ch0_done) m_busy = 0;
    if (sw_we && sw_sel == 2'd0) m_en = sw_wdata[0];
    else if (tend_acc) m_en = 0;
    if (sw_we && sw_sel == 2'd1) m_src = sw_wdata;
    if (sw_we && sw_sel == 2'd2) m_dst = sw_wdata;
    if (sw_we && sw_sel == 2'd3) m_cnt = sw_wdata[CNT_W-1:0];
    if (clr) m_frz = 0; else if (freeze_set) m_frz = 1;
    m_ready = 1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 req_ready", 32'(req_ready), 32'(m_ready));
    chk("R4/R5 ch0_req", 32'(ch0_req), 32'(m_pend));
    chk("R6 ch0_busy", 32'(ch0_busy), 32'(m_busy));
    chk("R7/R8/R9 ch0_en", 32'(ch0_en), 32'(m_en));
    chk("R7/R9 ch0_src", ch0_src, m_src);
    chk("R7/R9 ch0_dst", ch0_dst, m_dst);
    chk("R7/R9 ch0_cnt", 32'(ch0_cnt), 32'(m_cnt));
    chk("R12 frozen", 32'(frozen), 32'(m_frz));
    for (int k = 0; k < 3; k++) begin
      chk("R2/R3/R10 q_level", 32'(q_level[k*3 +: 3]), 32'(m_lvl[k]));
      chk("R3 q_overflow", 32'(q_overflow[k]), 32'(m_ovf[k]));
    end
  endtask

  task automatic idle();
    req_valid = 0; req_word = '0; ch0_grant = 0; ch0_done = 0; q_pop = '0;
    freeze_set = 0; sw_we = 0; sw_sel = '0; sw_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic send(logic [6:0] w);
    req_valid = 1; req_word = w; step();
  endtask

  task automatic sw(logic [1:0] s, logic [31:0] d);
    sw_we = 1; sw_sel = s; sw_wdata = d; step();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state while rst held
    check_all();
    rst = 0;
    step();
    // R1: ready after reset
    chk("R1 ready after reset", 32'(req_ready), 32'd1);

    // R5: handshake while disabled is ignored
    send(mk(0, 0, 0));
    chk("R5 hs disabled", 32'(ch0_req), 32'd0);
    sw(2'd1, 32'hA000_0010); sw(2'd2, 32'hB000_0020); sw(2'd3, 32'h0000_0040);
    sw(2'd0, 32'h1);
    // R4: handshake sets request
    send(mk(0, 0, 7));
    chk("R4 hs mode0 size7", 32'(ch0_req), 32'd1);
    // R6: grant -> busy
    ch0_grant = 1; step();
    chk("R6 busy after grant", 32'(ch0_busy), 32'd1);
    // R8: end while busy ignored
    send(mk(0, 1, 7));
    chk("R8 end while busy", 32'(ch0_en), 32'd1);
    // R5: handshake while busy dropped
    send(mk(0, 0, 1));
    chk("R5 hs while busy", 32'(ch0_req), 32'd0);
    ch0_done = 1; step();
    // R7: end accepted, settings held
    send(mk(0, 3, 7));
    chk("R7 en cleared", 32'(ch0_en), 32'd0);
    chk("R7 src held", ch0_src, 32'hA000_0010);
    // R9: external handshake cannot restart
    send(mk(0, 0, 0));
    chk("R9 no ext restart", 32'(ch0_en) | 32'(ch0_req), 32'd0);
    sw(2'd0, 32'h1);
    chk("R9 sw restart", 32'(ch0_en), 32'd1);
    // R11: unlisted channel 0 combos do nothing
    send(mk(0, 0, 5)); send(mk(0, 0, 6)); send(mk(0, 1, 6)); send(mk(0, 3, 6));
    chk("R11 no change", 32'(ch0_req), 32'd0);
    // R3: overflow queue 2 with mode/size noise
    for (int i = 0; i < 6; i++) send(mk(2, i % 4, 7 - i));
    chk("R3 full level", 32'(q_level[5:3]), 32'd4);
    chk("R3 overflow set", 32'(q_overflow[1]), 32'd1);
    req_valid = 1; req_word = mk(2, 0, 0); q_pop = 3'b010; step();
    chk("R3 push full with pop", 32'(q_level[5:3]), 32'd3);
    q_pop = 3'b001; step();
    chk("R3 pop empty", 32'(q_level[2:0]), 32'd0);
    // R10: flush with pop and freeze_set same cycle
    send(mk(1, 0, 0)); freeze_set = 1; step(); send(mk(0, 0, 2));
    req_valid = 1; req_word = mk(0, 2, 6); q_pop = 3'b111; freeze_set = 1; step();
    chk("R10 flush levels", 32'(q_level), 32'd0);
    chk("R10 flush pending/frozen", 32'(ch0_req) | 32'(frozen), 32'd0);
    chk("R10 ovf kept", 32'(q_overflow[1]), 32'd1);

    // random phase
    void'($urandom(32'd1751));
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 10) < 7;
      if ($urandom % 3 == 0) req_word = mk(0, $urandom % 4, $urandom % 8);
      else req_word = 7'($urandom);
      ch0_grant = ($urandom % 4) == 0;
      ch0_done = ($urandom % 6) == 0;
      q_pop = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
      freeze_set = ($urandom % 20) == 0;
      sw_we = ($urandom % 8) == 0;
      sw_sel = 2'($urandom);
      sw_wdata = $urandom;
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule